// File: doc/BRIEF.md
# GPIO Pad Configuration Register Bank

This block is a memory-mapped register bank that controls a row of general-purpose pins. Each pin has one 32-bit configuration word. The word holds the pin's output value, an output-disable flag, an input-disable flag and a 10-bit receive-option field. When read, the same word also returns the pin's synchronized input level and a host-ownership flag. Each pin also has a lock bit. Once that bit is set, the pin's word can no longer be changed over the bus. The lock bits and ownership flags come from strap inputs that are captured while reset is held, and software can only read them.

The first register holds the byte offset of the pad word array, so software can find the array without a fixed map. The lock words follow that register, one bit per pin. The bank drives a registered output-data vector and a registered output-enable vector. A pin drives only if it is owned by the host and its output-disable flag is clear. The bus port has one-cycle read and write strobes, and read data arrives with a valid pulse two clocks after the read strobe.

Top module: `padcfg_bank`

## Requirements
- R1: The word at byte address 0x00 always reads the parameter PAD_BASE (default 0x100), and writes to it have no effect.
- R2: The lock word at byte address 0x04+4k returns in bit j the lock strap of pin 32k+j, captured during reset. It is read-only.
- R3: Pin n's pad word sits at byte address PAD_BASE+4n. Bit 0 is the output value, bit 3 is the output disable, bit 4 is the input disable, and bits 23:14 are a receive-option field that reads back as written. After reset, bit 0 is 0, bit 3 is 1 and bit 4 is 0.
- R4: Pad-word bit 1 returns the pin's input level after a two-flop synchronizer. Writes to bit 1 have no effect.
- R5: Pad-word bit 27 returns the pin's ownership strap, captured during reset. Writes to it have no effect. Bits 2, 13:5 and 31:24 other than bit 27 read 0.
- R6: A write to the pad word of a pin whose lock bit is set changes none of that word's fields.
- R7: pin_out[n] equals pad-word bit 0. pin_oe[n] is high only when bit 3 is clear and the ownership flag is set. Both are 0 in reset and change on the second rising edge after the write is sampled.
- R8: bus_rvalid pulses for one cycle exactly two rising edges after each sampled bus_rd, with bus_rdata valid in that cycle. Addresses outside the pointer, the lock words and the pad array read 0, and writes to them change no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the straps are captured while it is high |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read data valid pulse |
| pin_in | input | NUM_PINS | Asynchronous pin input levels |
| pin_out | output | NUM_PINS | Registered output values |
| pin_oe | output | NUM_PINS | Registered output enables |
| lock_strap | input | NUM_PINS | Per-pin lock straps |
| owner_strap | input | NUM_PINS | Per-pin host ownership straps |

## Verification
The checks assume the following about the inputs:
- Reset is held for at least one clock before the lock and ownership registers are used, and the straps are stable while reset is high.
- Read and write strobes are never raised in the same cycle, and addresses are word aligned.
- pin_in may change at any time, so the bench waits at least three clocks after changing an input level before reading bit 1 back.

The stimulus keeps to these limits. It holds reset for three cycles with the straps already applied, and it issues each bus operation on its own at a falling edge. It covers a locked pin, an unowned pin, the last pin of the array, and addresses just past the lock words and the array.

// File: rtl/padcfg_pkg.sv
package padcfg_pkg;

  // Pad word bit positions; the host software decodes these, so they are fixed.
  localparam int TX_BIT    = 0;
  localparam int RXS_BIT   = 1;
  localparam int TXDIS_BIT = 3;
  localparam int RXDIS_BIT = 4;
  localparam int OWN_BIT   = 27;
  localparam int OPT_LSB   = 14;
  localparam int OPT_MSB   = 23;
  localparam int OPT_W     = OPT_MSB - OPT_LSB + 1;

  typedef enum logic [1:0] {
    REG_NONE,
    REG_PTR,
    REG_LOCK,
    REG_PAD
  } reg_kind_e;

  typedef struct packed {
    logic own;
    logic rxdis;
    logic txdis;
    logic rxs;
    logic tx;
  } pad_bits_t;

  function automatic logic [31:0] pad_word(pad_bits_t b, logic [OPT_W-1:0] opt);
    logic [31:0] w;
    w = '0;
    w[TX_BIT]            = b.tx;
    w[RXS_BIT]           = b.rxs;
    w[TXDIS_BIT]         = b.txdis;
    w[RXDIS_BIT]         = b.rxdis;
    w[OWN_BIT]           = b.own;
    w[OPT_MSB:OPT_LSB]   = opt;
    return w;
  endfunction

endpackage

// File: rtl/padcfg_addr_dec.sv
module padcfg_addr_dec
  import padcfg_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NUM_PINS   = 128,
  parameter int PAD_BASE   = 32'h100,
  parameter int LOCK_WORDS = 4,
  localparam int PIN_W     = $clog2(NUM_PINS),
  localparam int LW_W      = (LOCK_WORDS > 1) ? $clog2(LOCK_WORDS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [PIN_W-1:0]  pin_idx,
  output logic [LW_W-1:0]   lock_idx
);

  localparam logic [31:0] LOCK_HI = 32'(LOCK_WORDS);
  localparam logic [31:0] PAD_LO  = 32'(PAD_BASE / 4);
  localparam logic [31:0] PAD_HI  = 32'(PAD_BASE / 4 + NUM_PINS);

  logic [31:0] word_a;
  assign word_a = 32'(addr) >> 2;

  always_comb begin
    kind     = REG_NONE;
    pin_idx  = '0;
    lock_idx = '0;
    if (word_a == 32'd0) begin
      kind = REG_PTR;
    end else if (word_a <= LOCK_HI) begin
      kind     = REG_LOCK;
      lock_idx = LW_W'(word_a - 32'd1);
    end else if (word_a >= PAD_LO && word_a < PAD_HI) begin
      kind    = REG_PAD;
      pin_idx = PIN_W'(word_a - PAD_LO);
    end
  end

endmodule

// File: rtl/padcfg_sync.sv
module padcfg_sync #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

endmodule

// File: rtl/padcfg_opt_ram.sv
module padcfg_opt_ram #(
  parameter int DEPTH = 128,
  parameter int W     = 10,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  // Simple dual-port, read-first, registered read: maps to block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/padcfg_bank.sv
module padcfg_bank
  import padcfg_pkg::*;
#(
  parameter int NUM_PINS = 128,
  parameter int ADDR_W   = 12,
  parameter int PAD_BASE = 32'h100
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                bus_rvalid,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  input  logic [NUM_PINS-1:0] lock_strap,
  input  logic [NUM_PINS-1:0] owner_strap
);

  localparam int PIN_W      = $clog2(NUM_PINS);
  localparam int LOCK_WORDS = (NUM_PINS + 31) / 32;
  localparam int LW_W       = (LOCK_WORDS > 1) ? $clog2(LOCK_WORDS) : 1;
  localparam int LOCK_BITS  = LOCK_WORDS * 32;

  // Strap-loaded, read-only state
  logic [NUM_PINS-1:0] lock_q;
  logic [NUM_PINS-1:0] owner_q;
  // Bus-writable pad fields kept in flops (they feed the pins in parallel)
  logic [NUM_PINS-1:0] tx_q;
  logic [NUM_PINS-1:0] txdis_q;
  logic [NUM_PINS-1:0] rxdis_q;
  logic [NUM_PINS-1:0] rx_sync;

  reg_kind_e          dec_kind;
  logic [PIN_W-1:0]   dec_pin;
  logic [LW_W-1:0]    dec_lock;
  logic               wr_pad;

  logic [LOCK_BITS-1:0] lock_ext;
  logic [OPT_W-1:0]     s1_opt;
  logic                 s1_valid;
  reg_kind_e            s1_kind;
  pad_bits_t            s1_bits;
  logic [31:0]          s1_lock;

  logic unused_wbits;
  assign unused_wbits = ^{bus_wdata[31:24], bus_wdata[13:5], bus_wdata[2:1]};

  padcfg_addr_dec #(
    .ADDR_W    (ADDR_W),
    .NUM_PINS  (NUM_PINS),
    .PAD_BASE  (PAD_BASE),
    .LOCK_WORDS(LOCK_WORDS)
  ) dec_i (
    .addr    (bus_addr),
    .kind    (dec_kind),
    .pin_idx (dec_pin),
    .lock_idx(dec_lock)
  );

  padcfg_sync #(.W(NUM_PINS)) sync_i (
    .clk(clk),
    .rst(rst),
    .d  (pin_in),
    .q  (rx_sync)
  );

  // Lock enforcement sits in the write decode: a locked pin never sees a strobe.
  assign wr_pad = bus_wr && (dec_kind == REG_PAD) && !lock_q[dec_pin];

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q  <= lock_strap;
      owner_q <= owner_strap;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q    <= '0;
      txdis_q <= '1;
      rxdis_q <= '0;
    end else if (wr_pad) begin
      tx_q[dec_pin]    <= bus_wdata[TX_BIT];
      txdis_q[dec_pin] <= bus_wdata[TXDIS_BIT];
      rxdis_q[dec_pin] <= bus_wdata[RXDIS_BIT];
    end
  end

  padcfg_opt_ram #(.DEPTH(NUM_PINS), .W(OPT_W)) opt_ram_i (
    .clk  (clk),
    .we   (wr_pad),
    .waddr(dec_pin),
    .wdata(bus_wdata[OPT_MSB:OPT_LSB]),
    .re   (bus_rd),
    .raddr(dec_pin),
    .rdata(s1_opt)
  );

  assign lock_ext = LOCK_BITS'(lock_q);

  // Read stage 1: capture selected fields alongside the RAM read
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_kind  <= REG_NONE;
      s1_bits  <= '0;
      s1_lock  <= '0;
    end else begin
      s1_valid <= bus_rd;
      if (bus_rd) begin
        s1_kind       <= dec_kind;
        s1_bits.tx    <= tx_q[dec_pin];
        s1_bits.rxs   <= rx_sync[dec_pin];
        s1_bits.txdis <= txdis_q[dec_pin];
        s1_bits.rxdis <= rxdis_q[dec_pin];
        s1_bits.own   <= owner_q[dec_pin];
        s1_lock       <= lock_ext[32*int'(dec_lock) +: 32];
      end
    end
  end

  // Read stage 2: registered data mux
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= s1_valid;
      if (s1_valid) begin
        case (s1_kind)
          REG_PTR:  bus_rdata <= 32'(PAD_BASE);
          REG_LOCK: bus_rdata <= s1_lock;
          REG_PAD:  bus_rdata <= pad_word(s1_bits, s1_opt);
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end

  // Registered pin drive
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      pin_oe  <= '0;
    end else begin
      pin_out <= tx_q;
      pin_oe  <= ~txdis_q & owner_q;
    end
  end

endmodule

// File: rtl/padcfg_bank_chk.sv
module padcfg_bank_chk #(
  parameter int NUM_PINS = 128
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_rd,
  input logic                bus_rvalid,
  input logic [NUM_PINS-1:0] tx_q,
  input logic [NUM_PINS-1:0] txdis_q,
  input logic [NUM_PINS-1:0] lock_q,
  input logic [NUM_PINS-1:0] owner_q,
  input logic [NUM_PINS-1:0] pin_oe
);

  // R8: every read strobe yields a valid pulse two edges later
  a_r8_rvalid_follows_rd: assert property (@(posedge clk) disable iff (rst)
    bus_rd |-> ##2 bus_rvalid);

  // R8: no valid pulse without a read strobe two edges earlier
  a_r8_rvalid_has_rd: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_rd, 2));

  // R6: fields of locked pins never change
  a_r6_locked_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((((tx_q ^ $past(tx_q)) | (txdis_q ^ $past(txdis_q))) & lock_q) == '0));

  // R2 / R5: strap-loaded state is constant outside reset
  a_r2_straps_const: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($stable(lock_q) && $stable(owner_q)));

  // R7: no enable on a pin the host does not own
  a_r7_oe_owned: assert property (@(posedge clk) disable iff (rst)
    (pin_oe & ~owner_q) == '0);

  // R7: no enable while the output disable was set on the previous cycle
  a_r7_oe_txdis: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pin_oe & $past(txdis_q)) == '0));

endmodule

bind padcfg_bank padcfg_bank_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_rd    (bus_rd),
  .bus_rvalid(bus_rvalid),
  .tx_q      (tx_q),
  .txdis_q   (txdis_q),
  .lock_q    (lock_q),
  .owner_q   (owner_q),
  .pin_oe    (pin_oe)
);

// File: tb/padcfg_bank_tb_top.sv
module padcfg_bank_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_PINS   = 128;
  localparam int ADDR_W     = 12;
  localparam int PAD_BASE   = 32'h100;
  localparam logic [31:0] NO_OPT = ~32'h00FF_C000;

  typedef struct {
    logic [31:0] exp;
    logic [31:0] mask;
    string       tag;
  } sb_item_t;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                bus_wr = 1'b0;
  logic                bus_rd = 1'b0;
  logic [ADDR_W-1:0]   bus_addr = '0;
  logic [31:0]         bus_wdata = '0;
  logic [31:0]         bus_rdata;
  logic                bus_rvalid;
  logic [NUM_PINS-1:0] pin_in = '0;
  logic [NUM_PINS-1:0] pin_out;
  logic [NUM_PINS-1:0] pin_oe;
  logic [NUM_PINS-1:0] lock_strap = '0;
  logic [NUM_PINS-1:0] owner_strap = '1;

  sb_item_t sbq[$];
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  padcfg_bank #(
    .NUM_PINS(NUM_PINS),
    .ADDR_W  (ADDR_W),
    .PAD_BASE(PAD_BASE)
  ) dut_i (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .pin_in     (pin_in),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .lock_strap (lock_strap),
    .owner_strap(owner_strap)
  );

  function automatic logic [ADDR_W-1:0] pad_addr(int n);
    return ADDR_W'(PAD_BASE + 4 * n);
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic chk_pin(int n, logic eo, logic eoe, string tag);
    check(pin_out[n] === eo && pin_oe[n] === eoe, tag,
          {30'd0, pin_oe[n], pin_out[n]}, {30'd0, eoe, eo});
  endtask

  task automatic do_write(logic [ADDR_W-1:0] a, logic [31:0] d);
    bus_wr    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic do_read(logic [ADDR_W-1:0] a, logic [31:0] exp, logic [31:0] mask, string tag);
    sb_item_t it;
    it.exp  = exp;
    it.mask = mask;
    it.tag  = tag;
    sbq.push_back(it);
    bus_rd   = 1'b1;
    bus_addr = a;
    @(negedge clk);
    bus_rd   = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R8 unexpected rvalid", bus_rdata, 32'h0);
      end else begin
        sb_item_t it;
        it = sbq.pop_front();
        check((bus_rdata & it.mask) === (it.exp & it.mask), it.tag,
              bus_rdata & it.mask, it.exp & it.mask);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    lock_strap[3]    = 1'b1;
    lock_strap[40]   = 1'b1;
    lock_strap[127]  = 1'b1;
    owner_strap[7]   = 1'b0;
    owner_strap[64]  = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // Reset state (R7, R8)
    check(bus_rvalid === 1'b0, "R8 rvalid after reset", {31'd0, bus_rvalid}, 32'h0);
    check(pin_out === '0, "R7 pin_out after reset", 32'(pin_out != '0), 32'h0);
    check(pin_oe === '0, "R7 pin_oe after reset", 32'(pin_oe != '0), 32'h0);

    // R1 pointer, read-only
    do_read(12'h000, 32'h100, '1, "R1 pointer");
    do_write(12'h000, 32'h0000_DEAD);
    do_read(12'h000, 32'h100, '1, "R1 pointer after write");

    // R2 lock words from straps, read-only
    do_read(12'h004, 32'h0000_0008, '1, "R2 lock word 0");
    do_read(12'h008, 32'h0000_0100, '1, "R2 lock word 1");
    do_read(12'h00C, 32'h0000_0000, '1, "R2 lock word 2");
    do_read(12'h010, 32'h8000_0000, '1, "R2 lock word 3");
    do_write(12'h004, 32'hFFFF_FFFF);
    do_read(12'h004, 32'h0000_0008, '1, "R2 lock word 0 after write");

    // R3 reset value and field layout
    do_read(pad_addr(0), 32'h0800_0008, NO_OPT, "R3 pad0 reset");
    do_write(pad_addr(0), 32'h00A9_4001);
    check(pin_out[0] === 1'b0, "R7 pin_out latency", {31'd0, pin_out[0]}, 32'h0);
    @(negedge clk);
    chk_pin(0, 1'b1, 1'b1, "R7 pin0 drive");
    do_read(pad_addr(0), 32'h08A9_4001, '1, "R3 pad0 readback");

    // R5 read-only and reserved bits
    do_write(pad_addr(5), 32'hFFFF_FFFF);
    @(negedge clk);
    chk_pin(5, 1'b1, 1'b0, "R7 pin5 disabled");
    do_read(pad_addr(5), 32'h08FF_C019, '1, "R5 pad5 all ones write");

    do_write(pad_addr(0), 32'h00A9_4000);
    @(negedge clk);
    chk_pin(0, 1'b0, 1'b1, "R7 pin0 low");

    // R6 locked pin
    do_write(pad_addr(40), 32'h0000_0001);
    @(negedge clk);
    chk_pin(40, 1'b0, 1'b0, "R6 pin40 locked outputs");
    do_read(pad_addr(40), 32'h0800_0008, NO_OPT, "R6 pad40 locked");

    // R5 / R7 unowned pin
    do_write(pad_addr(7), 32'h0000_0001);
    @(negedge clk);
    chk_pin(7, 1'b1, 1'b0, "R7 pin7 unowned");
    do_read(pad_addr(7), 32'h0000_0001, '1, "R5 pad7 owner clear");

    // R4 synchronized input
    pin_in[9] = 1'b1;
    repeat (3) @(negedge clk);
    do_read(pad_addr(9), 32'h0800_000A, NO_OPT, "R4 pad9 input high");
    do_write(pad_addr(9), 32'h0000_0008);
    do_read(pad_addr(9), 32'h0800_000A, '1, "R4 pad9 bit1 write ignored");
    pin_in[9] = 1'b0;
    repeat (3) @(negedge clk);
    do_read(pad_addr(9), 32'h0800_0008, '1, "R4 pad9 input low");

    // R3 / R6 end of array
    do_write(pad_addr(126), 32'h0000_0010);
    @(negedge clk);
    chk_pin(126, 1'b0, 1'b1, "R7 pin126 enable");
    do_read(pad_addr(126), 32'h0800_0010, '1, "R3 pad126");
    do_write(pad_addr(127), 32'h0000_0001);
    do_read(pad_addr(127), 32'h0800_0008, NO_OPT, "R6 pad127 locked");

    // R8 unmapped addresses
    do_write(12'h300, 32'h0000_0001);
    do_write(12'h014, 32'h0000_0001);
    do_read(12'h300, 32'h0, '1, "R8 past array");
    do_read(12'h014, 32'h0, '1, "R8 past lock words");
    do_read(12'h0FC, 32'h0, '1, "R8 gap below array");
    do_read(pad_addr(0), 32'h08A9_4000, '1, "R8 pad0 unaliased");
    @(negedge clk);
    begin
      logic [NUM_PINS-1:0] eo;
      logic [NUM_PINS-1:0] eoe;
      eo = '0;
      eo[5] = 1'b1;
      eo[7] = 1'b1;
      eoe = '0;
      eoe[0] = 1'b1;
      eoe[126] = 1'b1;
      check(pin_out === eo, "R8 pin_out vector", 32'($countones(pin_out ^ eo)), 32'h0);
      check(pin_oe === eoe, "R7 pin_oe vector", 32'($countones(pin_oe ^ eoe)), 32'h0);
    end

    repeat (5) @(negedge clk);
    check(sbq.size() == 0, "R8 missing read responses", 32'(sbq.size()), 32'h0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule